// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog that runs on the bus clock. Software reaches it through one 32-bit configuration word on a simple write port, and it returns the stored preset on a read bus. The low field of the word holds a preset count. The hardware scales the preset by 256, so the countdown length in bus cycles is the preset times 256. The scaled value can reach 0xFFFFFF00 and always fits in 32 bits.

Enabling and servicing are not plain bits. Each has its own 2-bit key field in the word, and software must write the value 01 and then the value 10 to that field on two consecutive register writes. The enable key toggles the watchdog on or off; the same pair is used for both directions. The service key reloads the countdown from the preset.

While the watchdog is enabled, the counter goes down by one on every bus clock. When it reaches zero, a sticky timeout is raised. A static input sends the timeout either to an interrupt output or to a reset-request output. The enable state and the live counter value are also brought out for observation.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the watchdog is disabled, no timeout is raised, `rd_data` holds the reset preset `RST_PRESET`, and `count_o` equals `RST_PRESET*256`.
- R2: Two consecutive writes carrying 01 and then 10 in bits 25:24 (the enable key) invert `en_o`. Nothing else changes `en_o`.
- R3: Two consecutive writes carrying 01 and then 10 in bits 27:26 (the service key) load `count_o` with preset*256 and clear any timeout.
- R4: A key takes effect only if its 10 write comes directly after its 01 write. Any write between them that carries another value in that field (00 or 11, including a write aimed only at the other field) cancels it. A 10 write with no 01 before it does nothing.
- R5: The preset sits in bits 23:0 and changes only on a write whose bits 27:24 are all zero. `rd_data` returns the preset zero-extended, with bits 31:24 reading 0.
- R6: Turning the watchdog on loads the counter with preset*256. While enabled, the counter drops by exactly one per clock and stops at zero. While disabled, it holds its value.
- R7: The timeout is raised on the same edge where an enabled counter reaches zero, which is exactly preset*256 edges after the load. With a preset of 0 it is raised one edge after the load. Once raised, it stays until a service key or a disable.
- R8: With `act_reset_sel`=0 the timeout appears on `irq_o`; with `act_reset_sel`=1 it appears on `rst_req_o`. The two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| act_reset_sel | input | 1 | Static timeout routing: 0 selects interrupt, 1 selects reset request |
| rd_data | output | 32 | Register readback (preset, upper bits zero) |
| en_o | output | 1 | Watchdog enabled |
| count_o | output | 32 | Live countdown value |
| irq_o | output | 1 | Timeout as interrupt |
| rst_req_o | output | 1 | Timeout as reset request |

## Verification
The bench goes after broken key sequences: a 00, a 11, or a write aimed at the other field placed between 01 and 10, and a lone 10. A design that tracked keys per cycle rather than per write, or that never cleared a half-entered key, would then toggle or reload when it should not. It measures the expiry at exactly preset*256 edges after the load. An off-by-one in where the timeout is set would show up as one edge early or one edge late. It also disables the watchdog while a timeout is raised, loads a preset of zero, and writes key values alongside nonzero preset bits. These catch a timeout that is not cleared on disable, a zero preset that never expires, and key writes that overwrite the preset.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int KEY_W = 2;

    typedef enum logic [KEY_W-1:0] {
        KEY_IDLE = 2'b00,
        KEY_ARM  = 2'b01,
        KEY_FIRE = 2'b10,
        KEY_BAD  = 2'b11
    } key_code_e;

endpackage

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] field_i,
    output logic             fire_o
);

    typedef struct packed {
        logic armed;
    } key_st_t;

    key_st_t st_d, st_q;

    // Tracking advances on register writes only; idle cycles leave it alone.
    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        if (wr_en) begin
            fire_o      = st_q.armed && (field_i == KEY_FIRE);
            st_d.armed  = (field_i == KEY_ARM);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/kwd_down_cnt.sv
module kwd_down_cnt #(
    parameter int               CNT_W   = 32,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expired_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             expired;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (run_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        // Flag rises together with the step into zero (or at once if already zero).
        if (clear_i) begin
            st_d.expired = 1'b0;
        end else if (run_i && (st_q.cnt <= CNT_W'(1))) begin
            st_d.expired = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt     <= RST_VAL;
            st_q.expired <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign expired_o = st_q.expired;

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import kwd_pkg::*;
#(
    parameter int                  REG_W      = 32,
    parameter int                  PRESET_W   = 24,
    parameter int                  SCALE_SH   = 8,
    parameter int                  KEY_LSB    = 24,
    parameter logic [PRESET_W-1:0] RST_PRESET = 24'd4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [REG_W-1:0]             wr_data,
    input  logic                         act_reset_sel,
    output logic [REG_W-1:0]             rd_data,
    output logic                         en_o,
    output logic [PRESET_W+SCALE_SH-1:0] count_o,
    output logic                         irq_o,
    output logic                         rst_req_o
);

    localparam int CNT_W    = PRESET_W + SCALE_SH;
    localparam int N_KEYS   = 2;
    localparam int KEYS_W   = N_KEYS * KEY_W;
    localparam int KEY_TOP  = KEY_LSB + KEYS_W;
    localparam int IDX_EN   = 0;
    localparam int IDX_SVC  = 1;
    localparam logic [CNT_W-1:0] RST_CNT = {RST_PRESET, {SCALE_SH{1'b0}}};

    typedef struct packed {
        logic [PRESET_W-1:0] preset;
        logic                en;
    } ctl_st_t;

    ctl_st_t             ctl_d, ctl_q;
    logic [N_KEYS-1:0]   fire;
    logic [KEYS_W-1:0]   key_bits;
    logic                cnt_load, cnt_run, cnt_clear, expired;
    logic [CNT_W-1:0]    cnt_val;
    logic                unused_hi;

    assign key_bits  = wr_data[KEY_LSB +: KEYS_W];
    assign unused_hi = ^wr_data[REG_W-1:KEY_TOP] ^ ^wr_data[KEY_LSB-1:PRESET_W];

    generate
        for (genvar g = 0; g < N_KEYS; g++) begin : g_key
            kwd_key_seq u_key (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (wr_en),
                .field_i (key_bits[g*KEY_W +: KEY_W]),
                .fire_o  (fire[g])
            );
        end
    endgenerate

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en && (key_bits == '0)) begin
            ctl_d.preset = wr_data[PRESET_W-1:0];
        end
        if (fire[IDX_EN]) begin
            ctl_d.en = ~ctl_q.en;
        end
        cnt_load  = fire[IDX_SVC] | (fire[IDX_EN] & ~ctl_q.en);
        cnt_clear = fire[IDX_SVC] | (fire[IDX_EN] &  ctl_q.en);
        cnt_run   = ctl_q.en & ~fire[IDX_EN] & ~fire[IDX_SVC];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.preset <= RST_PRESET;
            ctl_q.en     <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    kwd_down_cnt #(
        .CNT_W   (CNT_W),
        .RST_VAL (RST_CNT)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i ({ctl_q.preset, {SCALE_SH{1'b0}}}),
        .run_i      (cnt_run),
        .clear_i    (cnt_clear),
        .cnt_o      (cnt_val),
        .expired_o  (expired)
    );

    assign rd_data   = REG_W'(ctl_q.preset);
    assign en_o      = ctl_q.en;
    assign count_o   = cnt_val;
    assign irq_o     = expired & ~act_reset_sel;
    assign rst_req_o = expired &  act_reset_sel;

endmodule

// File: rtl/kwd_chk.sv
module kwd_chk #(
    parameter int REG_W  = 32,
    parameter int CNT_W  = 32,
    parameter int KEYS_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [KEYS_W-1:0] wr_keys,
    input logic [REG_W-1:0]  rd_data,
    input logic              en_o,
    input logic [CNT_W-1:0]  count_o,
    input logic              irq_o,
    input logic              rst_req_o
);

    AST_EN_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_o)); // R2

    AST_PRESET_KEPT_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_keys != '0)) |=> $stable(rd_data)); // R5

    AST_STEP_DOWN_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && (count_o != '0) && !wr_en) |=> (count_o == $past(count_o) - CNT_W'(1))); // R6

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !wr_en) |=> $stable(count_o)); // R6

    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o || rst_req_o) && !wr_en) |=> (irq_o || rst_req_o)); // R7

    AST_ONE_ROUTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && rst_req_o)); // R8

endmodule

bind keyed_wdog kwd_chk #(
    .REG_W  (REG_W),
    .CNT_W  (CNT_W),
    .KEYS_W (KEYS_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_keys   (wr_data[KEY_LSB +: KEYS_W]),
    .rd_data   (rd_data),
    .en_o      (en_o),
    .count_o   (count_o),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
);

// File: tb/keyed_wdog_tb_top.sv
`timescale 1ns/1ps
module keyed_wdog_tb_top;

    localparam longint RSTP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        act_reset_sel = 1'b0;
    logic [31:0] rd_data;
    logic        en_o;
    logic [31:0] count_o;
    logic        irq_o;
    logic        rst_req_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    keyed_wdog dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .act_reset_sel (act_reset_sel),
        .rd_data       (rd_data),
        .en_o          (en_o),
        .count_o       (count_o),
        .irq_o         (irq_o),
        .rst_req_o     (rst_req_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: per-field history of written key values.
    int     h_en[$];
    int     h_sv[$];
    bit     m_en  = 0;
    longint m_cnt = RSTP * 256;
    longint m_pre = RSTP;
    bit     m_to  = 0;

    function automatic bit key_done(ref int h[$], input int v);
        h.push_back(v);
        if (h.size() > 2) void'(h.pop_front());
        if (h.size() == 2 && h[0] == 1 && h[1] == 2) begin
            h.delete();
            return 1'b1;
        end
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        bit     tog;
        bit     svc;
        longint nxt_pre;
        tog = 0;
        svc = 0;
        nxt_pre = m_pre;
        if (!rst_n) begin
            h_en.delete();
            h_sv.delete();
            m_en = 0; m_cnt = RSTP * 256; m_pre = RSTP; m_to = 0;
        end else begin
            if (wr_en) begin
                tog = key_done(h_en, int'(wr_data[25:24]));
                svc = key_done(h_sv, int'(wr_data[27:26]));
                if (wr_data[27:24] == 4'd0) nxt_pre = longint'(wr_data[23:0]);
            end
            if (svc) begin
                m_cnt = m_pre * 256;
                m_to  = 0;
            end else if (tog && !m_en) begin
                m_cnt = m_pre * 256;
            end else if (tog && m_en) begin
                m_to = 0;
            end else if (m_en) begin
                if (m_cnt <= 1) m_to = 1;
                if (m_cnt > 0) m_cnt = m_cnt - 1;
            end
            if (tog) m_en = !m_en;
            m_pre = nxt_pre;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(en_o == m_en, "R2 enable state", en_o, m_en);
            chk(longint'(count_o) == m_cnt, "R6 counter", count_o, m_cnt);
            chk(irq_o == (m_to && !act_reset_sel), "R8 irq route", irq_o, m_to && !act_reset_sel);
            chk(rst_req_o == (m_to && act_reset_sel), "R7 timeout on reset route", rst_req_o, m_to && act_reset_sel);
            chk(longint'(rd_data) == m_pre, "R5 readback", rd_data, m_pre);
        end
    end

    task automatic wr(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure_expiry(input longint exp, input string tag);
        longint n;
        n = 0;
        while (!(irq_o || rst_req_o) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp, tag, n, exp);
    endtask

    localparam logic [31:0] EN01 = 32'h0100_0000;
    localparam logic [31:0] EN10 = 32'h0200_0000;
    localparam logic [31:0] EN11 = 32'h0300_0000;
    localparam logic [31:0] SV01 = 32'h0400_0000;
    localparam logic [31:0] SV10 = 32'h0800_0000;
    localparam logic [31:0] SV11 = 32'h0C00_0000;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(en_o == 0, "R1 disabled", en_o, 0);
        chk(count_o == 32'(RSTP * 256), "R1 count", count_o, RSTP * 256);
        chk(rd_data == 32'(RSTP), "R1 preset", rd_data, RSTP);
        chk(!irq_o && !rst_req_o, "R1 no timeout", irq_o | rst_req_o, 0);

        // R5 preset write
        wr(32'd3);
        chk(rd_data == 32'd3, "R5 preset write", rd_data, 3);

        // R2 + R6 enable
        wr(EN01); wr(EN10);
        chk(en_o == 1, "R2 enable toggle on", en_o, 1);
        chk(count_o == 32'd768, "R6 load on enable", count_o, 768);
        measure_expiry(768, "R7 expiry edges");
        chk(irq_o == 1 && rst_req_o == 0, "R8 irq route", irq_o, 1);
        idle(5);
        chk(irq_o == 1, "R7 sticky", irq_o, 1);

        // R3 service
        wr(SV01); wr(SV10);
        chk(irq_o == 0, "R3 service clears", irq_o, 0);
        chk(count_o == 32'd768, "R3 service reload", count_o, 768);
        idle(20);
        chk(count_o == 32'd748, "R6 decrement", count_o, 748);

        // R4 broken sequences
        wr(SV01); wr(32'd3); wr(SV10);
        chk(count_o == 32'd745, "R4 00 breaks service key", count_o, 745);
        wr(SV01); wr(SV11); wr(SV10);
        chk(count_o == 32'd742, "R4 11 breaks service key", count_o, 742);
        wr(SV10);
        chk(count_o == 32'd741, "R4 lone 10 ignored", count_o, 741);
        wr(SV01); wr(EN01); wr(SV10);
        chk(count_o == 32'd738, "R4 other-field write breaks key", count_o, 738);
        chk(en_o == 1, "R4 enable untouched", en_o, 1);
        wr(EN01); wr(EN11); wr(EN10);
        chk(en_o == 1, "R4 broken enable key", en_o, 1);

        // R5 key writes keep preset; R2 toggle off; R6 hold
        wr(EN01 | 32'd5);
        chk(rd_data == 32'd3, "R5 key write keeps preset", rd_data, 3);
        wr(EN10 | 32'd7);
        chk(en_o == 0, "R2 enable toggle off", en_o, 0);
        chk(rd_data == 32'd3, "R5 key write keeps preset", rd_data, 3);
        idle(10);
        chk(count_o == 32'd734, "R6 hold while off", count_o, 734);

        // R8 reset route
        wr(32'd1);
        act_reset_sel = 1'b1;
        wr(EN01); wr(EN10);
        chk(count_o == 32'd256, "R6 reload preset 1", count_o, 256);
        measure_expiry(256, "R7 expiry edges preset 1");
        chk(rst_req_o == 1 && irq_o == 0, "R8 reset route", rst_req_o, 1);

        // R7 disable clears
        wr(EN01); wr(EN10);
        chk(rst_req_o == 0 && en_o == 0, "R7 disable clears", rst_req_o, 0);

        // R7 zero preset
        wr(32'd0);
        wr(EN01); wr(EN10);
        chk(count_o == 32'd0 && rst_req_o == 0, "R7 zero preset load", count_o, 0);
        idle(1);
        chk(rst_req_o == 1, "R7 zero preset expires", rst_req_o, 1);

        idle(3);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule